// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block is a hardware state machine that switches one gated logic domain on and off. A single-cycle request carries the wanted direction. The block then steps the domain's power controls in a fixed order. Between the steps it waits on handshake inputs: a pair of power-switch status vectors, an SRAM power-down acknowledge vector and a bus-protection acknowledge. Each step drives one output, so two control outputs never change in the same cycle.

Each wait samples its acknowledge once per poll interval. Each wait also has its own cycle budget. When that budget runs out, the sequence stops, a sticky error flag is raised and completion is reported. The control word keeps a fixed bit layout: bit 0 is the active-low domain reset, bit 1 is isolation, bit 2 is the first power switch, bit 3 is the second power switch and bit 4 is clock gating. A downstream register can decode the word directly. Bus protection drives a per-domain mask. When that mask is zero, the protection steps are removed from both sequences.

Top module: `pd_sequencer`

## Requirements
- R1: After reset the block is idle with the domain off. `ctrl` is 5'b10010 (reset low, isolation high, both switches off, clock gating on). `sram_pdn` is all ones, `bus_prot` equals `BP_MASK`, and `clk_en`, `busy`, `done`, `error` and `domain_on` are 0.
- R2: A power-up request does the following, each in a later cycle than the one before. Set `clk_en`. Set `ctrl[2]`. Set `ctrl[3]`. Wait for power good. Clear `ctrl[4]`. Clear `ctrl[1]`. Set `ctrl[0]`. Clear `sram_pdn`. Wait for `sram_ack` to be zero. Clear `bus_prot`. Wait for `bp_ack` low.
- R3: Power is good only when `pwr_sta & STA_MASK` is non-zero and `pwr_sta2 & STA_MASK` is non-zero. Status bits outside the mask, or only one status vector, never count as powered.
- R4: A power-down request does the following, each in a later cycle than the one before. Drive `bus_prot` to `BP_MASK`. Wait for `bp_ack` high. Set `sram_pdn` to all ones. Wait for `sram_ack` all ones. Clear `ctrl[0]`. Set `ctrl[1]`. Set `ctrl[4]`. Clear `ctrl[3]`. Clear `ctrl[2]`. Wait for power good to drop. Clear `clk_en`.
- R5: The SRAM waits finish only when every bit of `sram_ack` holds the target value. This is all zeros on power-up and all ones on power-down. A mixed vector ends in a timeout.
- R6: With `BP_MASK` zero, `bus_prot` stays 0 and both sequences skip the protection wait, whatever `bp_ack` does.
- R7: A wait is re-sampled every `POLL_CYCLES` cycles and lasts no more than `TIMEOUT_CYCLES` cycles. On expiry the sequence stops, `error` rises together with `done`, and `error` stays set until the next accepted request clears it.
- R8: A failed power-up drops `clk_en` in the cycle that reports the failure.
- R9: `clk_en` rises before any power switch is turned on. On power-down it falls only after power good has dropped, and never on a failed power-down.
- R10: A request that arrives while `busy` is high is dropped. It neither alters the running sequence nor starts another one.
- R11: `done` is a one-cycle pulse at the end of every sequence, with `busy` low. `domain_on` then shows the last successfully reached state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_on | input | 1 | Requested direction: 1 power up, 0 power down |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| error | output | 1 | Sticky timeout flag |
| domain_on | output | 1 | Last successfully reached state |
| clk_en | output | 1 | Functional clock enable of the domain |
| ctrl | output | 5 | Control word: [0] reset_n, [1] isolation, [2] switch 1, [3] switch 2, [4] clock gating |
| sram_pdn | output | SRAM_W | SRAM power-down controls |
| bus_prot | output | BP_W | Bus-protection enables |
| pwr_sta | input | STA_W | Primary power status |
| pwr_sta2 | input | STA_W | Secondary power status |
| sram_ack | input | SRAM_W | SRAM power-down acknowledges |
| bp_ack | input | 1 | Bus-protection acknowledge |

## Verification
A bench model of the domain answers every control change after a random delay. The bench timestamps the first cycle at which each step of R2 and R4 is reached, so a design that merges two steps into one cycle or swaps them fails the order check. Faults are injected one at a time:
- One case stalls the power switch.
- One case presents only unmasked bits on the secondary status. A design that ORs the two status vectors, or ignores the mask, would report power good.
- One case gives a half-acknowledged SRAM vector. A design that checks any bit instead of every bit would finish the wait.

Each fault must end in `error` and a correct `clk_en`. A second instance has a zero protection mask and an acknowledge that never rises, so a design that still waits for protection times out. Requests made mid-sequence must leave the order and the final state unchanged.

// File: rtl/pd_seq_pkg.sv
`timescale 1ns/1ps
package pd_seq_pkg;

    // Control word layout is fixed: bit 0 reset_n, 1 isolation, 2 switch 1,
    // 3 switch 2, 4 clock gating (packed struct lists MSB first).
    typedef struct packed {
        logic clk_gate;
        logic sw2;
        logic sw1;
        logic iso;
        logic rst_n;
    } pd_ctrl_t;

    localparam pd_ctrl_t CTRL_DOWN = '{clk_gate: 1'b1, sw2: 1'b0, sw1: 1'b0, iso: 1'b1, rst_n: 1'b0};

    typedef struct packed {
        logic pwr_good;
        logic sram_all0;
        logic sram_all1;
        logic prot_ack;
    } pd_acks_t;

    typedef enum logic [4:0] {
        S_IDLE,
        S_UP_SW1, S_UP_SW2, S_UP_WPWR, S_UP_CLK, S_UP_ISO, S_UP_RST,
        S_UP_SRAM, S_UP_WSRAM, S_UP_PROT, S_UP_WPROT,
        S_DN_PROT, S_DN_WPROT, S_DN_SRAM, S_DN_WSRAM, S_DN_RST, S_DN_ISO,
        S_DN_CLK, S_DN_SW2, S_DN_SW1, S_DN_WPWR
    } pd_state_t;

    function automatic logic is_wait(pd_state_t s);
        return (s == S_UP_WPWR) || (s == S_UP_WSRAM) || (s == S_UP_WPROT) ||
               (s == S_DN_WPROT) || (s == S_DN_WSRAM) || (s == S_DN_WPWR);
    endfunction

endpackage

// File: rtl/pd_seq_ack_eval.sv
`timescale 1ns/1ps
module pd_seq_ack_eval
    import pd_seq_pkg::*;
#(
    parameter int STA_W = 4,
    parameter int SRAM_W = 4,
    parameter logic [STA_W-1:0] STA_MASK = '1
) (
    input  logic [STA_W-1:0]  pwr_sta,
    input  logic [STA_W-1:0]  pwr_sta2,
    input  logic [SRAM_W-1:0] sram_ack,
    input  logic              bp_ack,
    output pd_acks_t          acks
);

    logic [STA_W-1:0] sta_a;
    logic [STA_W-1:0] sta_b;

    always_comb begin
        sta_a          = pwr_sta & STA_MASK;
        sta_b          = pwr_sta2 & STA_MASK;
        acks.pwr_good  = (|sta_a) && (|sta_b);
        acks.sram_all0 = (sram_ack == '0);
        acks.sram_all1 = (&sram_ack);
        acks.prot_ack  = bp_ack;
    end

endmodule

// File: rtl/pd_seq_timer.sv
`timescale 1ns/1ps
module pd_seq_timer #(
    parameter int POLL_CYCLES = 4,
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic poll_tick,
    output logic expired
);

    localparam int PW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam int EW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_CYCLES - 1);
    localparam logic [EW-1:0] TMO_LAST  = EW'(TIMEOUT_CYCLES - 1);

    logic [PW-1:0] poll_q;
    logic [EW-1:0] elap_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            poll_q <= '0;
            elap_q <= '0;
        end else begin
            poll_q <= (poll_q == POLL_LAST) ? '0 : poll_q + 1'b1;
            if (elap_q != TMO_LAST) begin
                elap_q <= elap_q + 1'b1;
            end
        end
    end

    assign poll_tick = run && (poll_q == POLL_LAST);
    assign expired   = run && (elap_q == TMO_LAST);

endmodule

// File: rtl/pd_seq_fsm.sv
`timescale 1ns/1ps
module pd_seq_fsm
    import pd_seq_pkg::*;
#(
    parameter bit PROT_USED = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  logic     req_on,
    input  pd_acks_t acks,
    input  logic     poll_tick,
    input  logic     expired,
    output pd_ctrl_t ctrl,
    output logic     sram_down,
    output logic     prot_on,
    output logic     clk_en,
    output logic     busy,
    output logic     done,
    output logic     error,
    output logic     domain_on,
    output logic     in_wait
);

    pd_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            ctrl      <= CTRL_DOWN;
            sram_down <= 1'b1;
            prot_on   <= 1'b1;
            clk_en    <= 1'b0;
            done      <= 1'b0;
            error     <= 1'b0;
            domain_on <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                S_IDLE: begin
                    if (req_valid) begin
                        error <= 1'b0;
                        if (req_on) begin
                            clk_en <= 1'b1;
                            st_q   <= S_UP_SW1;
                        end else begin
                            st_q <= PROT_USED ? S_DN_PROT : S_DN_SRAM;
                        end
                    end
                end
                // ---------------- power-up ----------------
                S_UP_SW1: begin
                    ctrl.sw1 <= 1'b1;
                    st_q     <= S_UP_SW2;
                end
                S_UP_SW2: begin
                    ctrl.sw2 <= 1'b1;
                    st_q     <= S_UP_WPWR;
                end
                S_UP_WPWR: begin
                    if (poll_tick && acks.pwr_good) begin
                        st_q <= S_UP_CLK;
                    end else if (expired) begin
                        clk_en <= 1'b0;
                        error  <= 1'b1;
                        done   <= 1'b1;
                        st_q   <= S_IDLE;
                    end
                end
                S_UP_CLK: begin
                    ctrl.clk_gate <= 1'b0;
                    st_q          <= S_UP_ISO;
                end
                S_UP_ISO: begin
                    ctrl.iso <= 1'b0;
                    st_q     <= S_UP_RST;
                end
                S_UP_RST: begin
                    ctrl.rst_n <= 1'b1;
                    st_q       <= S_UP_SRAM;
                end
                S_UP_SRAM: begin
                    sram_down <= 1'b0;
                    st_q      <= S_UP_WSRAM;
                end
                S_UP_WSRAM: begin
                    if (poll_tick && acks.sram_all0) begin
                        if (PROT_USED) begin
                            st_q <= S_UP_PROT;
                        end else begin
                            domain_on <= 1'b1;
                            done      <= 1'b1;
                            st_q      <= S_IDLE;
                        end
                    end else if (expired) begin
                        clk_en <= 1'b0;
                        error  <= 1'b1;
                        done   <= 1'b1;
                        st_q   <= S_IDLE;
                    end
                end
                S_UP_PROT: begin
                    prot_on <= 1'b0;
                    st_q    <= S_UP_WPROT;
                end
                S_UP_WPROT: begin
                    if (poll_tick && !acks.prot_ack) begin
                        domain_on <= 1'b1;
                        done      <= 1'b1;
                        st_q      <= S_IDLE;
                    end else if (expired) begin
                        clk_en <= 1'b0;
                        error  <= 1'b1;
                        done   <= 1'b1;
                        st_q   <= S_IDLE;
                    end
                end
                // ---------------- power-down ----------------
                S_DN_PROT: begin
                    prot_on <= 1'b1;
                    st_q    <= S_DN_WPROT;
                end
                S_DN_WPROT: begin
                    if (poll_tick && acks.prot_ack) begin
                        st_q <= S_DN_SRAM;
                    end else if (expired) begin
                        error <= 1'b1;
                        done  <= 1'b1;
                        st_q  <= S_IDLE;
                    end
                end
                S_DN_SRAM: begin
                    sram_down <= 1'b1;
                    st_q      <= S_DN_WSRAM;
                end
                S_DN_WSRAM: begin
                    if (poll_tick && acks.sram_all1) begin
                        st_q <= S_DN_RST;
                    end else if (expired) begin
                        error <= 1'b1;
                        done  <= 1'b1;
                        st_q  <= S_IDLE;
                    end
                end
                S_DN_RST: begin
                    ctrl.rst_n <= 1'b0;
                    st_q       <= S_DN_ISO;
                end
                S_DN_ISO: begin
                    ctrl.iso <= 1'b1;
                    st_q     <= S_DN_CLK;
                end
                S_DN_CLK: begin
                    ctrl.clk_gate <= 1'b1;
                    st_q          <= S_DN_SW2;
                end
                S_DN_SW2: begin
                    ctrl.sw2 <= 1'b0;
                    st_q     <= S_DN_SW1;
                end
                S_DN_SW1: begin
                    ctrl.sw1 <= 1'b0;
                    st_q     <= S_DN_WPWR;
                end
                S_DN_WPWR: begin
                    if (poll_tick && !acks.pwr_good) begin
                        clk_en    <= 1'b0;
                        domain_on <= 1'b0;
                        done      <= 1'b1;
                        st_q      <= S_IDLE;
                    end else if (expired) begin
                        error <= 1'b1;
                        done  <= 1'b1;
                        st_q  <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy    = (st_q != S_IDLE);
    assign in_wait = is_wait(st_q);

endmodule

// File: rtl/pd_sequencer.sv
`timescale 1ns/1ps
module pd_sequencer
    import pd_seq_pkg::*;
#(
    parameter int STA_W = 4,
    parameter int SRAM_W = 4,
    parameter int BP_W = 4,
    parameter logic [STA_W-1:0] STA_MASK = '1,
    parameter logic [BP_W-1:0]  BP_MASK = '1,
    parameter int POLL_CYCLES = 4,
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_on,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              domain_on,
    output logic              clk_en,
    output logic [4:0]        ctrl,
    output logic [SRAM_W-1:0] sram_pdn,
    output logic [BP_W-1:0]   bus_prot,
    input  logic [STA_W-1:0]  pwr_sta,
    input  logic [STA_W-1:0]  pwr_sta2,
    input  logic [SRAM_W-1:0] sram_ack,
    input  logic              bp_ack
);

    localparam bit PROT_USED = (BP_MASK != '0);

    pd_acks_t acks;
    pd_ctrl_t ctrl_s;
    logic     poll_tick;
    logic     expired;
    logic     in_wait;
    logic     sram_down;
    logic     prot_on;

    pd_seq_ack_eval #(
        .STA_W    (STA_W),
        .SRAM_W   (SRAM_W),
        .STA_MASK (STA_MASK)
    ) u_acks (
        .pwr_sta  (pwr_sta),
        .pwr_sta2 (pwr_sta2),
        .sram_ack (sram_ack),
        .bp_ack   (bp_ack),
        .acks     (acks)
    );

    pd_seq_timer #(
        .POLL_CYCLES    (POLL_CYCLES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (in_wait),
        .poll_tick (poll_tick),
        .expired   (expired)
    );

    pd_seq_fsm #(
        .PROT_USED (PROT_USED)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_on    (req_on),
        .acks      (acks),
        .poll_tick (poll_tick),
        .expired   (expired),
        .ctrl      (ctrl_s),
        .sram_down (sram_down),
        .prot_on   (prot_on),
        .clk_en    (clk_en),
        .busy      (busy),
        .done      (done),
        .error     (error),
        .domain_on (domain_on),
        .in_wait   (in_wait)
    );

    assign ctrl     = ctrl_s;
    assign sram_pdn = {SRAM_W{sram_down}};

    generate
        if (PROT_USED) begin : g_prot
            assign bus_prot = prot_on ? BP_MASK : '0;
        end else begin : g_noprot
            assign bus_prot = '0;
        end
    endgenerate

endmodule

// File: rtl/pd_sequencer_checker.sv
`timescale 1ns/1ps
module pd_sequencer_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic       domain_on,
    input logic       clk_en,
    input logic [4:0] ctrl
);

    assert_sw2_after_sw1_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl[3]) |-> ctrl[2]);
    assert_iso_after_clk_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl[1]) |-> !ctrl[4]);
    assert_rst_after_iso_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl[0]) |-> !ctrl[1]);
    assert_iso_after_rst_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl[1]) |-> !ctrl[0]);
    assert_clkgate_after_iso_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl[4]) |-> ctrl[1]);
    assert_sw1_after_sw2_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl[2]) |-> !ctrl[3]);
    assert_clk_en_drop_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_en) |-> done);
    assert_error_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> done);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_on_word_R11: assert property (@(posedge clk) disable iff (rst)
        (done && domain_on && !error) |-> (ctrl == 5'b01101));

endmodule

bind pd_sequencer pd_sequencer_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .domain_on (domain_on),
    .clk_en    (clk_en),
    .ctrl      (ctrl)
);

// File: tb/pd_sequencer_tb.sv
`timescale 1ns/1ps
module pd_lag #(
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic target,
    input  logic stuck,
    output logic q
);
    int cnt;
    int dly;
    always @(posedge clk) begin
        if (rst) begin
            q   <= INIT;
            cnt <= 0;
            dly <= 2;
        end else if (!stuck && (target != q)) begin
            if (cnt >= dly) begin
                q   <= target;
                cnt <= 0;
                dly <= 1 + int'($urandom_range(9, 0));
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            cnt <= 0;
        end
    end
endmodule

module pd_plant #(
    parameter int STA_W = 4,
    parameter int SRAM_W = 4,
    parameter int BP_W = 4,
    parameter logic [STA_W-1:0] STA_MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        ctrl,
    input  logic [SRAM_W-1:0] sram_pdn,
    input  logic [BP_W-1:0]   bus_prot,
    input  logic              stuck_pwr,
    input  logic              bad_sta2,
    input  logic              mixed_sram,
    output logic [STA_W-1:0]  sta1,
    output logic [STA_W-1:0]  sta2,
    output logic [SRAM_W-1:0] sram_ack,
    output logic              bp_ack
);
    logic pwr_q;
    logic sram_q;
    logic [SRAM_W-1:0] mix;

    pd_lag #(.INIT(1'b0)) u_pwr  (.clk(clk), .rst(rst), .target(ctrl[2] & ctrl[3]), .stuck(stuck_pwr), .q(pwr_q));
    pd_lag #(.INIT(1'b1)) u_sram (.clk(clk), .rst(rst), .target(&sram_pdn), .stuck(mixed_sram), .q(sram_q));
    pd_lag #(.INIT(1'b1)) u_bp   (.clk(clk), .rst(rst), .target(|bus_prot), .stuck(1'b0), .q(bp_ack));

    always_comb begin
        for (int i = 0; i < SRAM_W; i++) mix[i] = 1'(i % 2);
    end

    assign sta1     = pwr_q ? STA_MASK : '0;
    assign sta2     = bad_sta2 ? ~STA_MASK : (pwr_q ? STA_MASK : '0);
    assign sram_ack = mixed_sram ? mix : {SRAM_W{sram_q}};
endmodule

module pd_sequencer_tb;
    localparam int STA_W = 4;
    localparam int SRAM_W = 4;
    localparam int BP_W = 4;
    localparam logic [STA_W-1:0] STA_MASK = 4'b0100;
    localparam logic [BP_W-1:0]  BP_MASK = 4'b0110;
    localparam int POLL = 3;
    localparam int TMO = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // instance with bus protection
    logic req_valid = 1'b0, req_on = 1'b0;
    logic busy, done, error, domain_on, clk_en;
    logic [4:0] ctrl;
    logic [SRAM_W-1:0] sram_pdn, sram_ack;
    logic [BP_W-1:0] bus_prot;
    logic [STA_W-1:0] sta1, sta2;
    logic bp_ack;
    logic stuck_pwr = 1'b0, bad_sta2 = 1'b0, mixed_sram = 1'b0;

    pd_sequencer #(.STA_W(STA_W), .SRAM_W(SRAM_W), .BP_W(BP_W), .STA_MASK(STA_MASK),
                   .BP_MASK(BP_MASK), .POLL_CYCLES(POLL), .TIMEOUT_CYCLES(TMO)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_on(req_on), .busy(busy), .done(done),
        .error(error), .domain_on(domain_on), .clk_en(clk_en), .ctrl(ctrl), .sram_pdn(sram_pdn),
        .bus_prot(bus_prot), .pwr_sta(sta1), .pwr_sta2(sta2), .sram_ack(sram_ack), .bp_ack(bp_ack));

    pd_plant #(.STA_W(STA_W), .SRAM_W(SRAM_W), .BP_W(BP_W), .STA_MASK(STA_MASK)) u_plant (
        .clk(clk), .rst(rst), .ctrl(ctrl), .sram_pdn(sram_pdn), .bus_prot(bus_prot),
        .stuck_pwr(stuck_pwr), .bad_sta2(bad_sta2), .mixed_sram(mixed_sram),
        .sta1(sta1), .sta2(sta2), .sram_ack(sram_ack), .bp_ack(bp_ack));

    // instance without bus protection
    logic req_valid_b = 1'b0, req_on_b = 1'b0;
    logic busy_b, done_b, error_b, domain_on_b, clk_en_b;
    logic [4:0] ctrl_b;
    logic [SRAM_W-1:0] sram_pdn_b, sram_ack_b;
    logic [BP_W-1:0] bus_prot_b;
    logic [STA_W-1:0] sta1_b, sta2_b;
    logic bp_ack_b;

    pd_sequencer #(.STA_W(STA_W), .SRAM_W(SRAM_W), .BP_W(BP_W), .STA_MASK(STA_MASK),
                   .BP_MASK('0), .POLL_CYCLES(POLL), .TIMEOUT_CYCLES(TMO)) u_dut_noprot (
        .clk(clk), .rst(rst), .req_valid(req_valid_b), .req_on(req_on_b), .busy(busy_b), .done(done_b),
        .error(error_b), .domain_on(domain_on_b), .clk_en(clk_en_b), .ctrl(ctrl_b), .sram_pdn(sram_pdn_b),
        .bus_prot(bus_prot_b), .pwr_sta(sta1_b), .pwr_sta2(sta2_b), .sram_ack(sram_ack_b), .bp_ack(bp_ack_b));

    pd_plant #(.STA_W(STA_W), .SRAM_W(SRAM_W), .BP_W(BP_W), .STA_MASK(STA_MASK)) u_plant_b (
        .clk(clk), .rst(rst), .ctrl(ctrl_b), .sram_pdn(sram_pdn_b), .bus_prot(bus_prot_b),
        .stuck_pwr(1'b0), .bad_sta2(1'b0), .mixed_sram(1'b0),
        .sta1(sta1_b), .sta2(sta2_b), .sram_ack(sram_ack_b), .bp_ack(bp_ack_b));

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit powered(input logic [STA_W-1:0] a, input logic [STA_W-1:0] b);
        return ((a & STA_MASK) != 0) && ((b & STA_MASK) != 0);
    endfunction

    // step k of the expected sequence, reached once bit k is set
    function automatic logic [10:0] progress(input bit on);
        bit pw = powered(sta1, sta2);
        if (on)
            return {!bp_ack, bus_prot == '0, sram_ack == '0, sram_pdn == '0, ctrl[0], !ctrl[1],
                    !ctrl[4], pw, ctrl[3], ctrl[2], clk_en};
        else
            return {!clk_en, !pw, !ctrl[2], !ctrl[3], ctrl[4], ctrl[1], !ctrl[0],
                    sram_ack == '1, sram_pdn == '1, bp_ack, bus_prot == BP_MASK};
    endfunction

    int last_len;

    task automatic run_seq(input bit on, input bit chk_order, input bit exp_err,
                           input bit exp_on, input bit inject, input string tag);
        int t[11];
        int n;
        logic [10:0] p;
        bit ok;
        int bad;
        for (int i = 0; i < 11; i++) t[i] = -1;
        @(negedge clk);
        req_valid = 1'b1;
        req_on = on;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                req_valid = 1'b0;
                check(error == 1'b0, "R7", {tag, " error cleared on accept"}, error, 0);
            end
            if (inject && n == 3) begin
                req_valid = 1'b1;
                req_on = !on;
            end
            if (inject && n == 4) req_valid = 1'b0;
            p = progress(on);
            for (int i = 0; i < 11; i++) if (p[i] && t[i] < 0) t[i] = n;
        end while (!done && n < 2000);
        last_len = n;
        check(done == 1'b1, "R11", {tag, " done seen"}, done, 1);
        check(busy == 1'b0, "R11", {tag, " idle at done"}, busy, 0);
        check(error == exp_err, "R7", {tag, " error flag"}, error, exp_err);
        check(domain_on == exp_on, "R11", {tag, " final state"}, domain_on, exp_on);
        if (chk_order) begin
            ok = (t[0] >= 1);
            bad = 0;
            for (int i = 1; i < 11; i++) if (ok && !(t[i] > t[i-1])) begin ok = 0; bad = i; end
            check(ok, on ? "R2" : "R4", {tag, " step order (bad step index)"}, bad, 0);
        end
        @(negedge clk);
        check(!done && !busy, "R10", {tag, " no pulse or restart after done"}, {done, busy}, 0);
    endtask

    task automatic run_b(input bit on, input string tag);
        int n = 0;
        bit prot_seen = 1'b0;
        @(negedge clk);
        req_valid_b = 1'b1;
        req_on_b = on;
        do begin
            @(negedge clk);
            n++;
            req_valid_b = 1'b0;
            if (bus_prot_b != '0) prot_seen = 1'b1;
        end while (!done_b && n < 2000);
        check(done_b && !error_b, "R6", {tag, " completes without protection wait"}, error_b, 0);
        check(domain_on_b == on, "R6", {tag, " final state"}, domain_on_b, on);
        check(!prot_seen, "R6", {tag, " bus_prot stays zero"}, prot_seen, 0);
    endtask

    initial begin
        int seed_val;
        bit dir;
        seed_val = $urandom(32'h5eed);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ctrl == 5'b10010, "R1", "ctrl word", ctrl, 5'b10010);
        check(sram_pdn == '1 && bus_prot == BP_MASK, "R1", "sram/prot", {sram_pdn, bus_prot}, {4'hF, BP_MASK});
        check({clk_en, busy, done, error, domain_on} == 5'b0, "R1", "status",
              {clk_en, busy, done, error, domain_on}, 0);

        // directed clean sequences (R2 R4 R5 R9)
        run_seq(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "up");
        check(clk_en == 1'b1, "R9", "clk_en after up", clk_en, 1);
        run_seq(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "down");
        check(clk_en == 1'b0, "R9", "clk_en after down", clk_en, 0);

        // random delays, random mid-sequence requests (R10)
        dir = 1'b1;
        for (int k = 0; k < 16; k++) begin
            run_seq(dir, 1'b1, 1'b0, dir, 1'($urandom_range(1, 0)), "rand");
            repeat (int'($urandom_range(3, 0))) @(negedge clk);
            dir = !dir;
        end

        // stalled power switch on power-up (R7 R8)
        stuck_pwr = 1'b1;
        run_seq(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "pwr stall");
        check(last_len >= TMO, "R7", "wait length before timeout", last_len, TMO);
        check(clk_en == 1'b0, "R8", "clk_en after failed up", clk_en, 0);
        repeat (5) @(negedge clk);
        check(error == 1'b1, "R7", "error sticky", error, 1);
        stuck_pwr = 1'b0;
        run_seq(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "recover1");

        // secondary status shows only unmasked bits (R3)
        bad_sta2 = 1'b1;
        run_seq(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "sta2 bad");
        check(ctrl[4] == 1'b1 && ctrl[1] == 1'b1, "R3", "domain stays gated", ctrl, 5'b10000);
        bad_sta2 = 1'b0;
        run_seq(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "recover2");

        // mixed SRAM acknowledge on power-up and power-down (R5)
        mixed_sram = 1'b1;
        run_seq(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "sram mix up");
        mixed_sram = 1'b0;
        run_seq(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "recover3");
        run_seq(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "up2");
        mixed_sram = 1'b1;
        run_seq(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "sram mix down");
        check(clk_en == 1'b1, "R9", "clk_en kept on failed down", clk_en, 1);
        check(ctrl[0] == 1'b1, "R5", "reset not applied before SRAM ack", ctrl[0], 1);
        mixed_sram = 1'b0;
        run_seq(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "recover4");

        // zero protection mask instance (R6)
        run_b(1'b1, "noprot up");
        run_b(1'b0, "noprot down");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule